// File: doc/BRIEF.md
# Per-Area Endian Select and Alignment Guard

This block sits between a CPU's load/store path and the external bus. Every data access request carries an address, a size (byte, half-word or word), a flag that marks an update of the stack pointer or program counter, and an already decoded memory-area number. The block checks the request's alignment and passes it on one cycle later. It also reports which byte order applies to that access.

An ordinary data access that is not aligned to its size does not reach the bus. Instead it produces a one-cycle address-error pulse. A pointer update is never trapped: the low address bits are cleared so that the address lands on the boundary for its size.

Byte order is selected by an 8-bit control register, with one bit for each area or pair of areas. A 0 in a bit means little-endian and a 1 means big-endian. The bit that covers areas 9 and 10 is held at little-endian while the boot input is asserted.

Top module: `area_endian_align`

## Requirements
- R1: The size code is 0 for byte, 1 for half-word and 2 for word, and code 3 is treated as word. A byte is aligned at any address. A half-word needs address bit 0 clear. A word needs address bits 1:0 clear.
- R2: A valid request that is not a pointer update and is misaligned raises `addr_err_o` for exactly one cycle, the cycle after the request. `bus_valid_o` stays low in that cycle.
- R3: A valid pointer-update request never raises `addr_err_o`. Its output address has bit 0 cleared for a half-word and bits 1:0 cleared for a word. A byte address passes unchanged.
- R4: An accepted request appears one cycle later on `bus_valid_o`, `bus_addr_o` and `bus_size_o`. Data accesses keep their address unchanged.
- R5: The control register resets to 0x00. When `ctl_we_i` is high it loads `ctl_wdata_i`. `ctl_rdata_o` shows the value from the next cycle on.
- R6: `bus_big_o` is the control bit for the request's area, as held in the register in the request cycle. The bit assignments are: bit 0 for areas 4–5, bit 1 for area 6, bit 2 for areas 7–8, bit 3 for areas 9–10, bit 4 for areas 11–12, bit 5 for areas 13–14, bit 6 for areas 15–16, and bit 7 for areas 17–18.
- R7: Areas 0–3 and every area above 18 always report little-endian (`bus_big_o`=0).
- R8: While `boot_i` is high, areas 9–10 report little-endian. Control bit 3 is also cleared and reads back 0 from the next cycle on, and a write to bit 3 has no effect.
- R9: A cycle without `req_valid_i` produces neither `bus_valid_o` nor `addr_err_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | 32 | Request byte address |
| req_size_i | input | 2 | Access size code |
| req_ptr_upd_i | input | 1 | Request rewrites SP or PC |
| req_area_i | input | 5 | Decoded memory-area number |
| boot_i | input | 1 | Boot mode; locks areas 9–10 to little-endian |
| ctl_we_i | input | 1 | Control register write enable |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register current value |
| bus_valid_o | output | 1 | Accepted access toward the bus |
| bus_addr_o | output | 32 | Access address, realigned for pointer updates |
| bus_size_o | output | 2 | Access size code |
| bus_big_o | output | 1 | 1 = big-endian for this access |
| addr_err_o | output | 1 | Address-error pulse |

## Verification
The bench aims at misaligned pointer updates. A design that traps them would raise a false address error, and one that does not realign them would put an odd address on the bus. It also uses size code 3 and every area edge (3/4, 6/7, 18/19), where an off-by-one in the area map flips the byte order of a neighbouring area. It writes bit 3 while boot is asserted and issues an access in the same cycle as a register write. A design that ignores the lock, or that uses the newly written value too early, reports the wrong byte order there.

// File: rtl/eaa_pkg.sv
package eaa_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } size_e;

    // lowest area number governed by control bit g
    function automatic int area_lo(input int g);
        if (g == 0) return 4;
        if (g == 1) return 6;
        return 7 + 2 * (g - 2);
    endfunction

    // highest area number governed by control bit g
    function automatic int area_hi(input int g);
        if (g == 0) return 5;
        if (g == 1) return 6;
        return area_lo(g) + 1;
    endfunction

endpackage

// File: rtl/eaa_align_check.sv
module eaa_align_check
    import eaa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    output logic              misaligned_o,
    output logic [ADDR_W-1:0] forced_addr_o
);
    logic [1:0] low_mask;

    always_comb begin
        unique case (size_e'(size_i))
            SZ_BYTE: low_mask = 2'b00;
            SZ_HALF: low_mask = 2'b01;
            default: low_mask = 2'b11;
        endcase
        misaligned_o  = |(addr_i[1:0] & low_mask);
        forced_addr_o = {addr_i[ADDR_W-1:2], addr_i[1:0] & ~low_mask};
    end
endmodule

// File: rtl/eaa_area_select.sv
module eaa_area_select
    import eaa_pkg::*;
#(
    parameter int AREA_W = 5,
    parameter int CTL_W  = 8
) (
    input  logic [AREA_W-1:0] area_i,
    input  logic [CTL_W-1:0]  ctl_eff_i,
    output logic              big_o
);
    logic [CTL_W-1:0] hit;

    for (genvar g = 0; g < CTL_W; g++) begin : g_bit
        localparam int LO = area_lo(g);
        localparam int HI = area_hi(g);
        assign hit[g] = (area_i == AREA_W'(LO)) || (area_i == AREA_W'(HI));
    end

    assign big_o = |(hit & ctl_eff_i);
endmodule

// File: rtl/area_endian_align.sv
module area_endian_align
    import eaa_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int AREA_W   = 5,
    parameter int CTL_W    = 8,
    parameter int BOOT_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [31:0]       req_addr_i,
    input  logic [1:0]        req_size_i,
    input  logic              req_ptr_upd_i,
    input  logic [4:0]        req_area_i,
    input  logic              boot_i,
    input  logic              ctl_we_i,
    input  logic [7:0]        ctl_wdata_i,
    output logic [7:0]        ctl_rdata_o,
    output logic              bus_valid_o,
    output logic [31:0]       bus_addr_o,
    output logic [1:0]        bus_size_o,
    output logic              bus_big_o,
    output logic              addr_err_o
);
    localparam logic [CTL_W-1:0] BOOT_MASK = CTL_W'(1) << BOOT_BIT;

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic              bus_valid;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        size;
        logic              big;
        logic              err;
    } state_t;

    state_t state_d, state_q;

    logic              misaligned;
    logic [ADDR_W-1:0] forced_addr;
    logic [CTL_W-1:0]  ctl_eff;
    logic              area_big;

    eaa_align_check #(.ADDR_W(ADDR_W)) align_i (
        .addr_i       (req_addr_i),
        .size_i       (req_size_i),
        .misaligned_o (misaligned),
        .forced_addr_o(forced_addr)
    );

    assign ctl_eff = boot_i ? (state_q.ctl & ~BOOT_MASK) : state_q.ctl;

    eaa_area_select #(.AREA_W(AREA_W), .CTL_W(CTL_W)) area_i (
        .area_i   (req_area_i),
        .ctl_eff_i(ctl_eff),
        .big_o    (area_big)
    );

    always_comb begin
        logic trap;
        state_d = state_q;
        trap    = req_valid_i && !req_ptr_upd_i && misaligned;

        state_d.err       = trap;
        state_d.bus_valid = req_valid_i && !trap;
        if (req_valid_i) begin
            state_d.addr = req_ptr_upd_i ? forced_addr : req_addr_i;
            state_d.size = req_size_i;
            state_d.big  = area_big;
        end

        if (ctl_we_i)
            state_d.ctl = ctl_wdata_i;
        if (boot_i)
            state_d.ctl = state_d.ctl & ~BOOT_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign ctl_rdata_o = state_q.ctl;
    assign bus_valid_o = state_q.bus_valid;
    assign bus_addr_o  = state_q.addr;
    assign bus_size_o  = state_q.size;
    assign bus_big_o   = state_q.big;
    assign addr_err_o  = state_q.err;

    // R2: an error comes only from a valid, non-pointer request
    a_r2_err_source: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err_o |-> $past(req_valid_i && !req_ptr_upd_i));

    // R2: an error never coincides with a bus access
    a_r2_err_blocks_bus: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err_o |-> !bus_valid_o);

    // R3: pointer updates never trap
    a_r3_ptr_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ptr_upd_i) |=> !addr_err_o);

    // R1: a word on the bus is word aligned
    a_r1_word_aligned_out: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_o && bus_size_o[1]) |-> (bus_addr_o[1:0] == 2'b00));

    // R5: a write outside boot shows up in the read-back value
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we_i && !boot_i) |=> (ctl_rdata_o == $past(ctl_wdata_i)));

    // R8: boot clears the locked bit
    a_r8_boot_lock: assert property (@(posedge clk) disable iff (!rst_n)
        boot_i |=> !ctl_rdata_o[BOOT_BIT]);

    // R9: idle cycles produce nothing
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !(bus_valid_o || addr_err_o));
endmodule

// File: tb/area_endian_align_tb_top.sv
module area_endian_align_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [31:0] req_addr_i = '0;
    logic [1:0]  req_size_i = '0;
    logic        req_ptr_upd_i = 1'b0;
    logic [4:0]  req_area_i = '0;
    logic        boot_i = 1'b0;
    logic        ctl_we_i = 1'b0;
    logic [7:0]  ctl_wdata_i = '0;
    logic [7:0]  ctl_rdata_o;
    logic        bus_valid_o;
    logic [31:0] bus_addr_o;
    logic [1:0]  bus_size_o;
    logic        bus_big_o;
    logic        addr_err_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [7:0] m_ctl = 8'h00;

    always #2 clk = ~clk;

    area_endian_align dut_i (.*);

    function automatic logic f_misal(input logic [31:0] a, input logic [1:0] s);
        if (s == 2'd0) return 1'b0;
        if (s == 2'd1) return a[0];
        return |a[1:0];
    endfunction

    function automatic logic [31:0] f_force(input logic [31:0] a, input logic [1:0] s);
        if (s == 2'd0) return a;
        if (s == 2'd1) return {a[31:1], 1'b0};
        return {a[31:2], 2'b00};
    endfunction

    function automatic int f_bit(input logic [4:0] area);
        if (area == 5'd4 || area == 5'd5) return 0;
        if (area == 5'd6) return 1;
        if (area >= 5'd7 && area <= 5'd18) return 2 + (int'(area) - 7) / 2;
        return -1;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive one cycle at the negedge, check the registered result at the next negedge
    task automatic step(input logic v, input logic [31:0] a, input logic [1:0] s,
                        input logic p, input logic [4:0] ar, input logic bt,
                        input logic we, input logic [7:0] wd, input string tag);
        logic e_err, e_vld, e_big;
        logic [31:0] e_addr;
        logic [7:0] eff;
        int b;
        req_valid_i = v; req_addr_i = a; req_size_i = s; req_ptr_upd_i = p;
        req_area_i = ar; boot_i = bt; ctl_we_i = we; ctl_wdata_i = wd;
        e_err  = v && !p && f_misal(a, s);
        e_vld  = v && !e_err;
        e_addr = p ? f_force(a, s) : a;
        eff    = bt ? (m_ctl & 8'hF7) : m_ctl;
        b      = f_bit(ar);
        e_big  = (b >= 0) ? eff[b] : 1'b0;
        if (we) m_ctl = wd;
        if (bt) m_ctl[3] = 1'b0;
        @(negedge clk);
        check({tag, " err"}, 32'(addr_err_o), 32'(e_err));
        check({tag, " valid"}, 32'(bus_valid_o), 32'(e_vld));
        if (e_vld) begin
            check({tag, " addr"}, bus_addr_o, e_addr);
            check({tag, " size"}, 32'(bus_size_o), 32'(s));
            check({tag, " big"}, 32'(bus_big_o), 32'(e_big));
        end
        check({tag, " ctl"}, 32'(ctl_rdata_o), 32'(m_ctl));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'hA5C3_1F07));
        repeat (3) @(negedge clk);
        check("R5 reset ctl", 32'(ctl_rdata_o), 32'h0);
        check("R9 reset valid", 32'(bus_valid_o), 32'h0);
        check("R2 reset err", 32'(addr_err_o), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 alignment cases
        step(1, 32'h1003, 2'd0, 0, 5'd4, 0, 0, 8'h00, "R1 byte odd");
        step(1, 32'h1002, 2'd1, 0, 5'd4, 0, 0, 8'h00, "R1 half even");
        step(1, 32'h1001, 2'd1, 0, 5'd4, 0, 0, 8'h00, "R2 half odd");
        step(1, 32'h1002, 2'd2, 0, 5'd4, 0, 0, 8'h00, "R2 word bit1");
        step(1, 32'h1002, 2'd3, 0, 5'd4, 0, 0, 8'h00, "R1 size3 as word");
        step(0, 32'h1001, 2'd1, 0, 5'd4, 0, 0, 8'h00, "R2 one-cycle pulse");
        // R3 pointer realign
        step(1, 32'h2003, 2'd2, 1, 5'd6, 0, 0, 8'h00, "R3 word realign");
        step(1, 32'h2003, 2'd1, 1, 5'd6, 0, 0, 8'h00, "R3 half realign");
        step(1, 32'h2003, 2'd0, 1, 5'd6, 0, 0, 8'h00, "R3 byte unchanged");
        // R5/R6 register write, access in same cycle uses old value
        step(1, 32'h0, 2'd2, 0, 5'd4, 0, 1, 8'hFF, "R6 same-cycle old value");
        for (int ar = 0; ar < 32; ar++)
            step(1, 32'h40, 2'd2, 0, 5'(ar), 0, 0, 8'h00,
                 (ar < 4 || ar > 18) ? "R7 uncovered area" : "R6 area map");
        step(0, 32'h0, 2'd0, 0, 5'd0, 0, 1, 8'hFF, "R5 restore");
        // R8 boot lock
        step(1, 32'h8, 2'd2, 0, 5'd9, 1, 0, 8'h00, "R8 boot area9");
        step(1, 32'h8, 2'd2, 0, 5'd10, 1, 1, 8'hFF, "R8 boot write bit3");
        step(1, 32'h8, 2'd2, 0, 5'd11, 0, 0, 8'h00, "R8 neighbour kept");
        step(0, 32'h8, 2'd2, 0, 5'd9, 0, 0, 8'h00, "R9 idle");
        // random mix
        for (int i = 0; i < 2000; i++) begin
            step($urandom % 4 != 0, $urandom, 2'($urandom % 4), $urandom % 3 == 0,
                 5'($urandom % 24), $urandom % 8 == 0, $urandom % 4 == 0,
                 8'($urandom), "R4 random");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule